// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder

This block sits behind the comparator bank of an N-bit flash converter. The bank presents 2^N-1 comparator decisions, each one LSB above its neighbour, so a clean input is a run of ones starting at the lowest comparator and running up to the input level, with zeros above. On a sample strobe the block captures that word. In the following cycle it repairs isolated out-of-place bits, reduces the repaired word to an N-bit binary result, and also forms the reflected Gray form of that result.

Repair uses a three-way majority vote. Each bit is replaced by the majority of itself and its two neighbours. The virtual neighbour below the lowest comparator counts as one, and the virtual neighbour above the highest counts as zero. A flag pulses alongside the result whenever the vote changed any bit, so the system can count bubble events.

Results flow out as a stream with a valid strobe and no ready. The comparators cannot wait, so the consumer must take each result in the cycle that `code_valid` is high; there is no back-pressure. Between valid pulses the code outputs hold the last result.

Top module: `flash_therm_encoder`

## Requirements
- R1: While `rst_n` is low, `code_bin`, `code_gray`, `code_valid` and `sparkle_seen` are all zero.
- R2: A high `sample_stb` at a rising edge produces exactly one high cycle of `code_valid`, two rising edges later. Strobes on consecutive cycles give results on consecutive cycles, in order.
- R3: At an edge where `sample_stb` is low, `comp_bits` is ignored. After such edges `code_valid` stays low and `code_bin`/`code_gray` keep their last values.
- R4: For a clean thermometer word (bit 0 is the lowest comparator), `code_bin` equals the number of ones. All zeros give 0 and all ones give 2^N-1.
- R5: Each bit is corrected to the majority of the bit below, itself and the bit above. The virtual bit below bit 0 is 1 and the virtual bit above the top bit is 0.
- R6: A single zero with ones on both sides (for N=3, 0010111) is filled. The result is the count of the corrected word (here 4), not the position of the highest one.
- R7: At the ends of the word, an isolated one in the top bit is cleared (1000000 gives 0). A zero in bit 0 below a one in bit 1 is filled (0000110 gives 3).
- R8: `sparkle_seen` is high in the `code_valid` cycle exactly when the vote changed at least one bit. It is low in every other cycle.
- R9: `code_gray` equals `code_bin` XOR (`code_bin` >> 1) for every result.
- R10: There is no back-pressure. Each result is presented for one cycle and then held, unflagged, on the code outputs until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_stb | input | 1 | Capture the comparator word at this edge |
| comp_bits | input | 2^RES_BITS-1 | Comparator decisions, bit 0 lowest threshold |
| code_bin | output | RES_BITS | Binary result |
| code_gray | output | RES_BITS | Gray-coded result |
| code_valid | output | 1 | One-cycle strobe marking a new result |
| sparkle_seen | output | 1 | Vote altered the captured word of this result |

## Verification
A corrupted capture register or a wrong vote boundary shows up as a wrong `code_bin` in the very `code_valid` cycle of the affected sample: two edges after the strobe. A vote that is too weak or too strong also shows up there as a wrong `sparkle_seen` value. A broken strobe path shows up as a missing, doubled or misplaced valid pulse. It can also show as code outputs that drift between pulses; this is visible one edge after the strobe that should or should not have been taken. The end cases of the word (bit 0 and the top bit) are exercised separately, because their virtual neighbours are the part of the vote most easily wired the wrong way round.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic int levels_of(input int res_bits);
    return (1 << res_bits) - 1;
  endfunction

endpackage

// File: rtl/flash_capture.sv
module flash_capture #(
  parameter int LEVELS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [LEVELS-1:0] bits_i,
  output logic [LEVELS-1:0] word_q,
  output logic              word_vld_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      word_vld_q <= 1'b0;
    end else begin
      word_vld_q <= stb_i;
      if (stb_i) word_q <= bits_i;
    end
  end

endmodule

// File: rtl/flash_vote.sv
module flash_vote
  import flash_enc_pkg::*;
#(
  parameter int LEVELS = 7
) (
  input  logic [LEVELS-1:0] raw_i,
  output logic [LEVELS-1:0] fixed_o,
  output logic              changed_o
);

  for (genvar g = 0; g < LEVELS; g++) begin : g_bit
    logic below, above;
    if (g == 0) begin : g_bottom
      assign below = 1'b1;
    end else begin : g_mid_lo
      assign below = raw_i[g-1];
    end
    if (g == LEVELS - 1) begin : g_top
      assign above = 1'b0;
    end else begin : g_mid_hi
      assign above = raw_i[g+1];
    end
    assign fixed_o[g] = maj3(below, raw_i[g], above);
  end

  assign changed_o = |(fixed_o ^ raw_i);

endmodule

// File: rtl/flash_count.sv
module flash_count #(
  parameter int LEVELS = 7,
  parameter int W      = 3
) (
  input  logic [LEVELS-1:0] word_i,
  output logic [W-1:0]      bin_o,
  output logic [W-1:0]      gray_o
);

  always_comb begin
    bin_o = '0;
    for (int i = 0; i < LEVELS; i++) begin
      bin_o = bin_o + W'(word_i[i]);
    end
  end

  assign gray_o = bin_o ^ (bin_o >> 1);

endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder
  import flash_enc_pkg::*;
#(
  parameter int RES_BITS = 3,
  localparam int LEVELS  = (1 << RES_BITS) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_stb,
  input  logic [LEVELS-1:0]   comp_bits,
  output logic [RES_BITS-1:0] code_bin,
  output logic [RES_BITS-1:0] code_gray,
  output logic                code_valid,
  output logic                sparkle_seen
);

  logic [LEVELS-1:0]   cap_word;
  logic                cap_vld;
  logic [LEVELS-1:0]   fixed_word;
  logic                vote_changed;
  logic [RES_BITS-1:0] enc_bin, enc_gray;

  flash_capture #(.LEVELS(LEVELS)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_i     (sample_stb),
    .bits_i    (comp_bits),
    .word_q    (cap_word),
    .word_vld_q(cap_vld)
  );

  flash_vote #(.LEVELS(LEVELS)) u_vote (
    .raw_i    (cap_word),
    .fixed_o  (fixed_word),
    .changed_o(vote_changed)
  );

  flash_count #(.LEVELS(LEVELS), .W(RES_BITS)) u_cnt (
    .word_i(fixed_word),
    .bin_o (enc_bin),
    .gray_o(enc_gray)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_bin     <= '0;
      code_gray    <= '0;
      code_valid   <= 1'b0;
      sparkle_seen <= 1'b0;
    end else begin
      code_valid   <= cap_vld;
      sparkle_seen <= cap_vld & vote_changed;
      if (cap_vld) begin
        code_bin  <= enc_bin;
        code_gray <= enc_gray;
      end
    end
  end

endmodule

// File: rtl/flash_therm_encoder_chk.sv
module flash_therm_encoder_chk #(
  parameter int RES_BITS = 3,
  localparam int LEVELS  = (1 << RES_BITS) - 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_stb,
  input logic [LEVELS-1:0]   comp_bits,
  input logic [RES_BITS-1:0] code_bin,
  input logic [RES_BITS-1:0] code_gray,
  input logic                code_valid,
  input logic                sparkle_seen
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> ##1 code_valid);

  assert_valid_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> $past(sample_stb, 2));

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |-> ($stable(code_bin) && $stable(code_gray)));

  assert_flag_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sparkle_seen |-> code_valid);

  assert_gray_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_gray[RES_BITS-1] == code_bin[RES_BITS-1]);

endmodule

bind flash_therm_encoder flash_therm_encoder_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_stb  (sample_stb),
  .comp_bits   (comp_bits),
  .code_bin    (code_bin),
  .code_gray   (code_gray),
  .code_valid  (code_valid),
  .sparkle_seen(sparkle_seen)
);

// File: tb/flash_therm_encoder_tb.sv
module flash_therm_encoder_tb;

  localparam int RB = 3;
  localparam int LV = (1 << RB) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_stb = 1'b0;
  logic [LV-1:0] comp_bits = '0;
  logic [RB-1:0] code_bin, code_gray;
  logic          code_valid, sparkle_seen;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_therm_encoder #(.RES_BITS(RB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .comp_bits(comp_bits),
    .code_bin(code_bin), .code_gray(code_gray), .code_valid(code_valid),
    .sparkle_seen(sparkle_seen)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gray_of(input int b);
    return b ^ (b >> 1);
  endfunction

  // one strobe, checks pulse placement, code, gray, flag
  task automatic one_sample(input string req, input logic [LV-1:0] w,
                            input int exp_bin, input int exp_flag);
    @(negedge clk); comp_bits = w; sample_stb = 1'b1;
    @(negedge clk); sample_stb = 1'b0;
    check({req, " R2 no early valid"}, code_valid, 0);
    @(negedge clk);
    check({req, " R2 valid"}, code_valid, 1);
    check({req, " bin"}, code_bin, exp_bin);
    check({req, " R9 gray"}, code_gray, gray_of(exp_bin));
    check({req, " R8 flag"}, sparkle_seen, exp_flag);
    @(negedge clk);
    check({req, " R2 single pulse"}, code_valid, 0);
    check({req, " R8 flag drops"}, sparkle_seen, 0);
    check({req, " R10 held"}, code_bin, exp_bin);
  endtask

  task automatic t_reset();
    check("R1 bin", code_bin, 0);
    check("R1 gray", code_gray, 0);
    check("R1 valid", code_valid, 0);
    check("R1 flag", sparkle_seen, 0);
  endtask

  task automatic t_clean();
    one_sample("R4 zeros", 7'b0000000, 0, 0);
    one_sample("R4 ones", 7'b1111111, 7, 0);
    one_sample("R4 five", 7'b0011111, 5, 0);
    one_sample("R4 one", 7'b0000001, 1, 0);
  endtask

  task automatic t_inner_sparkle();
    one_sample("R6 inner zero", 7'b0010111, 4, 1);
    one_sample("R5 inner one", 7'b0100011, 2, 1);
  endtask

  task automatic t_ends();
    one_sample("R7 top one", 7'b1000000, 0, 1);
    one_sample("R7 bottom zero", 7'b0000110, 3, 1);
    one_sample("R5 top gap", 7'b1011111, 6, 1);
  endtask

  task automatic t_ignore();
    one_sample("R3 setup", 7'b0011111, 5, 0);
    comp_bits = 7'b1111111;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3 no valid", code_valid, 0);
      check("R3 bin held", code_bin, 5);
      check("R3 gray held", code_gray, gray_of(5));
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk); comp_bits = 7'b0000011; sample_stb = 1'b1;
    @(negedge clk); comp_bits = 7'b0010111;
    @(negedge clk); sample_stb = 1'b0;
    check("R2 b2b first valid", code_valid, 1);
    check("R2 b2b first bin", code_bin, 2);
    check("R8 b2b first flag", sparkle_seen, 0);
    @(negedge clk);
    check("R2 b2b second valid", code_valid, 1);
    check("R2 b2b second bin", code_bin, 4);
    check("R8 b2b second flag", sparkle_seen, 1);
    @(negedge clk);
    check("R10 b2b end", code_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_clean();
    t_inner_sparkle();
    t_ends();
    t_ignore();
    t_back_to_back();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule